// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer

This block turns two in-phase switch commands, one for the upper and one for the lower transistor of a half-bridge leg, into two gate-enable outputs. The commands and the enable line come from another clock domain and pass through two-flop synchronisers. A pulse filter on each command line then removes glitches. A hand-over stage inserts a fixed dead interval whenever conduction moves from one switch to the other, and it refuses to drive both gates at once.

Shutdown qualifiers stop both gates: a global enable, a fault stop and an undervoltage flag for each supply. The two sides re-arm in different ways after undervoltage. The upper gate stays off after its supply recovers until its command shows a fresh rising edge. The lower gate simply takes the present level of its command again. The filter lengths and the dead interval are given in clock cycles. A parameter selects between an IGBT setting and a MOSFET setting. The defaults (IGBT) are 19 filter cycles on each line and 38 dead cycles.

Top module: `hb_gate_sequencer`

## Requirements
- R1: With only `hin_raw` high (and the upper side armed), `gate_hi` goes high at the (FILT+3)-th rising clock edge after the change, where FILT = 19 by default. `lin_raw` drives `gate_lo` in the same way.
- R2: `gate_hi` and `gate_lo` are never high in the same cycle.
- R3: While both filtered commands are high, both gates are low.
- R4: When conduction hands over from one gate to the other, both gates are low for exactly DEAD clock cycles (38 by default) before the other gate rises.
- R5: A command pulse shorter than FILT clock cycles has no effect on either gate. A pulse a few cycles longer than FILT does pass.
- R6: When `en_raw` goes low, both gates are low from the third rising edge after the change.
- R7: While `fault_stop` is high, both gates are low from the next rising edge, with no dead interval.
- R8: After a shutdown ends, a gate that was switched off by it waits the dead interval before it turns on again. After a one-cycle stop it rises at the (DEAD+1)-th edge.
- R9: `uv_high` forces `gate_hi` low at the next edge. After `uv_high` clears, `gate_hi` stays low even if `hin_raw` is still high, until `hin_raw` shows a new rising edge.
- R10: `uv_low` forces both gates low at the next edge. After it clears, `gate_lo` follows the present level of `lin_raw` with no edge needed.
- R11: During and just after reset both gates are low. The upper side starts disarmed and arms on the first rising edge of its filtered command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hin_raw | input | 1 | Upper-switch command, asynchronous, high asks for on |
| lin_raw | input | 1 | Lower-switch command, asynchronous, high asks for on |
| en_raw | input | 1 | Global enable, asynchronous, low stops both gates |
| fault_stop | input | 1 | Fault shutdown, synchronous, high stops both gates |
| uv_high | input | 1 | Upper supply undervoltage, synchronous |
| uv_low | input | 1 | Lower supply undervoltage, synchronous |
| gate_hi | output | 1 | Upper gate enable |
| gate_lo | output | 1 | Lower gate enable |

## Verification
The properties assume that `fault_stop`, `uv_high` and `uv_low` are already synchronous to `clk`. They also assume that a command edge, once made, is held longer than the filter length, so every hand-over the checker sees was really requested. The bench drives all inputs on the falling clock edge. It holds each command level for well over FILT cycles, except in the scenario that tests short pulses on purpose. It lets the block settle in the idle state between scenarios, so every dead-interval window starts from a known output state.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic {
        SW_IGBT   = 1'b0,
        SW_MOSFET = 1'b1
    } sw_kind_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } hb_pair_t;

    function automatic int unsigned pick_filt(sw_kind_e kind, bit upper,
                                              int unsigned f_igbt,
                                              int unsigned f_mos_hi,
                                              int unsigned f_mos_lo);
        if (kind == SW_IGBT) return f_igbt;
        return upper ? f_mos_hi : f_mos_lo;
    endfunction

    function automatic int unsigned pick_dead(sw_kind_e kind,
                                              int unsigned d_igbt,
                                              int unsigned d_mos);
        return (kind == SW_IGBT) ? d_igbt : d_mos;
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hb_pulse_filter.sv
module hb_pulse_filter #(
    parameter int unsigned LEN = 19
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int unsigned CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] run;

    // The output takes the new level once LEN consecutive samples agree.
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= 1'b0;
            run  <= '0;
        end else if (din == dout) begin
            run <= '0;
        end else if (run == LAST) begin
            dout <= din;
            run  <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/hb_handover.sv
module hb_handover
    import hb_pkg::*;
#(
    parameter int unsigned DEAD = 38
) (
    input  logic     clk,
    input  logic     rst,
    input  hb_pair_t cmd,
    input  logic     drive_ok,
    input  logic     uv_high,
    input  logic     uv_low,
    output hb_pair_t gate
);
    localparam int unsigned DW = $clog2(DEAD + 1);
    localparam logic [DW-1:0] DLOAD = DW'(DEAD - 1);

    logic [DW-1:0] dead_left;
    logic          hi_armed;
    logic          hin_prev;
    logic          hi_rise;
    logic          dead_done;
    logic          all_ok;
    hb_pair_t      want;
    hb_pair_t      nxt;

    assign hi_rise   = cmd.hi & ~hin_prev;
    assign dead_done = (dead_left == '0);
    assign all_ok    = drive_ok & ~uv_low;

    always_comb begin
        want.hi = cmd.hi & ~cmd.lo & all_ok & ~uv_high & (hi_armed | hi_rise);
        want.lo = cmd.lo & ~cmd.hi & all_ok;
        nxt.hi  = want.hi & ~gate.lo & dead_done;
        nxt.lo  = want.lo & ~gate.hi & dead_done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate      <= '0;
            dead_left <= '0;
            hi_armed  <= 1'b0;
            hin_prev  <= 1'b0;
        end else begin
            gate     <= nxt;
            hin_prev <= cmd.hi;
            hi_armed <= uv_high ? 1'b0 : (hi_armed | hi_rise);
            if ((gate.hi & ~nxt.hi) | (gate.lo & ~nxt.lo))
                dead_left <= DLOAD;
            else if (!dead_done)
                dead_left <= dead_left - 1'b1;
        end
    end
endmodule

// File: rtl/hb_gate_sequencer.sv
module hb_gate_sequencer
    import hb_pkg::*;
#(
    parameter sw_kind_e    KIND        = SW_IGBT,
    parameter int unsigned FILT_IGBT   = 19,
    parameter int unsigned FILT_MOS_HI = 10,
    parameter int unsigned FILT_MOS_LO = 15,
    parameter int unsigned DEAD_IGBT   = 38,
    parameter int unsigned DEAD_MOS    = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic hin_raw,
    input  logic lin_raw,
    input  logic en_raw,
    input  logic fault_stop,
    input  logic uv_high,
    input  logic uv_low,
    output logic gate_hi,
    output logic gate_lo
);
    localparam int unsigned FILT_HI  = pick_filt(KIND, 1'b1, FILT_IGBT, FILT_MOS_HI, FILT_MOS_LO);
    localparam int unsigned FILT_LO  = pick_filt(KIND, 1'b0, FILT_IGBT, FILT_MOS_HI, FILT_MOS_LO);
    localparam int unsigned DEAD_CYC = pick_dead(KIND, DEAD_IGBT, DEAD_MOS);

    logic [2:0] synced;
    hb_pair_t   filt;
    hb_pair_t   gate;

    hb_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({en_raw, hin_raw, lin_raw}),
        .q_sync  (synced)
    );

    hb_pulse_filter #(.LEN(FILT_HI)) u_filt_hi (
        .clk  (clk),
        .rst  (rst),
        .din  (synced[1]),
        .dout (filt.hi)
    );

    hb_pulse_filter #(.LEN(FILT_LO)) u_filt_lo (
        .clk  (clk),
        .rst  (rst),
        .din  (synced[0]),
        .dout (filt.lo)
    );

    hb_handover #(.DEAD(DEAD_CYC)) u_hand (
        .clk      (clk),
        .rst      (rst),
        .cmd      (filt),
        .drive_ok (synced[2] & ~fault_stop),
        .uv_high  (uv_high),
        .uv_low   (uv_low),
        .gate     (gate)
    );

    assign gate_hi = gate.hi;
    assign gate_lo = gate.lo;
endmodule

// File: rtl/hb_gate_sequencer_chk.sv
module hb_gate_sequencer_chk #(
    parameter int unsigned DEAD = 38
) (
    input logic clk,
    input logic rst,
    input logic fault_stop,
    input logic uv_high,
    input logic uv_low,
    input logic gate_hi,
    input logic gate_lo
);
    localparam int unsigned RW = $clog2(DEAD + 1);

    logic [RW-1:0] low_run;
    logic          seen_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run <= '0;
            seen_on <= 1'b0;
        end else begin
            if (gate_hi | gate_lo) seen_on <= 1'b1;
            if (gate_hi | gate_lo)          low_run <= '0;
            else if (low_run != RW'(DEAD))  low_run <= low_run + 1'b1;
        end
    end

    a_r2_never_both: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi && gate_lo));

    a_r7_fault_stops: assert property (@(posedge clk) disable iff (rst)
        fault_stop |=> (!gate_hi && !gate_lo));

    a_r9_uvh_stops_hi: assert property (@(posedge clk) disable iff (rst)
        uv_high |=> !gate_hi);

    a_r10_uvl_stops_both: assert property (@(posedge clk) disable iff (rst)
        uv_low |=> (!gate_hi && !gate_lo));

    a_r4_dead_before_hi: assert property (@(posedge clk) disable iff (rst)
        ($rose(gate_hi) && seen_on) |-> (low_run == RW'(DEAD)));

    a_r4_dead_before_lo: assert property (@(posedge clk) disable iff (rst)
        ($rose(gate_lo) && seen_on) |-> (low_run == RW'(DEAD)));
endmodule

bind hb_gate_sequencer hb_gate_sequencer_chk #(.DEAD(DEAD_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fault_stop (fault_stop),
    .uv_high    (uv_high),
    .uv_low     (uv_low),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo)
);

// File: tb/sim_hb_gate_sequencer.sv
`timescale 1ns/1ps
module sim_hb_gate_sequencer;
    localparam int FILT = 19;
    localparam int DEAD = 38;
    localparam int LAT  = FILT + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hin_raw = 1'b0, lin_raw = 1'b0, en_raw = 1'b1;
    logic fault_stop = 1'b0, uv_high = 1'b0, uv_low = 1'b0;
    logic gate_hi, gate_lo;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    hb_gate_sequencer u0 (
        .clk(clk), .rst(rst), .hin_raw(hin_raw), .lin_raw(lin_raw),
        .en_raw(en_raw), .fault_stop(fault_stop), .uv_high(uv_high),
        .uv_low(uv_low), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        hin_raw = 0; lin_raw = 0; fault_stop = 0; uv_high = 0; uv_low = 0; en_raw = 1;
        cyc(FILT + DEAD + 10);
    endtask

    task automatic t_reset();
        chk("R11 gate_hi in reset", gate_hi, 1'b0);
        chk("R11 gate_lo in reset", gate_lo, 1'b0);
        rst = 0;
        cyc(4);
        chk("R11 gate_hi after reset", gate_hi, 1'b0);
        chk("R11 gate_lo after reset", gate_lo, 1'b0);
    endtask

    task automatic t_inphase();
        idle();
        lin_raw = 1;
        cyc(LAT - 1);
        chk("R1 gate_lo before latency", gate_lo, 1'b0);
        cyc(1);
        chk("R1 gate_lo at latency", gate_lo, 1'b1);
        chk("R2 gate_hi stays low", gate_hi, 1'b0);
        idle();
        hin_raw = 1;
        cyc(LAT - 1);
        chk("R1 gate_hi before latency", gate_hi, 1'b0);
        cyc(1);
        chk("R1 gate_hi at latency (R11 first rise arms)", gate_hi, 1'b1);
    endtask

    task automatic t_short_pulse();
        bit seen;
        idle();
        seen = 0;
        hin_raw = 1;
        cyc(FILT - 1);
        hin_raw = 0;
        for (int i = 0; i < 3 * FILT; i++) begin
            cyc(1);
            if (gate_hi) seen = 1;
        end
        chk("R5 short hi pulse suppressed", seen, 1'b0);
        seen = 0;
        lin_raw = 1;
        cyc(FILT + 3);
        lin_raw = 0;
        for (int i = 0; i < 3 * FILT; i++) begin
            cyc(1);
            if (gate_lo) seen = 1;
        end
        chk("R5 longer lo pulse passes", seen, 1'b1);
    endtask

    task automatic t_handover(input bit lo_to_hi);
        int t_off, t_on;
        bit both;
        idle();
        if (lo_to_hi) lin_raw = 1; else hin_raw = 1;
        cyc(LAT + 2);
        t_off = -1; t_on = -1; both = 0;
        hin_raw = lo_to_hi; lin_raw = !lo_to_hi;
        for (int n = 1; n < 200; n++) begin
            cyc(1);
            if (gate_hi && gate_lo) both = 1;
            if (t_off < 0 && !(lo_to_hi ? gate_lo : gate_hi)) t_off = n;
            if (t_on < 0 && (lo_to_hi ? gate_hi : gate_lo)) t_on = n;
        end
        chk_int("R1 old gate falls after latency", t_off, LAT);
        chk_int("R4 dead cycles on hand-over", t_on - t_off, DEAD);
        chk("R2 no overlap during hand-over", both, 1'b0);
    endtask

    task automatic t_interlock();
        idle();
        lin_raw = 1;
        cyc(LAT + 2);
        hin_raw = 1;
        cyc(LAT + 2);
        chk("R3 interlock gate_lo", gate_lo, 1'b0);
        chk("R3 interlock gate_hi", gate_hi, 1'b0);
        cyc(DEAD + 10);
        chk("R3 interlock holds gate_hi", gate_hi, 1'b0);
        hin_raw = 0;
        cyc(LAT + DEAD + 2);
        chk("R3 gate_lo returns when conflict ends", gate_lo, 1'b1);
    endtask

    task automatic t_enable();
        idle();
        lin_raw = 1;
        cyc(LAT + 2);
        en_raw = 0;
        cyc(2);
        chk("R6 gate_lo before enable reaches", gate_lo, 1'b1);
        cyc(1);
        chk("R6 gate_lo low after enable drop", gate_lo, 1'b0);
        cyc(5);
        en_raw = 1;
        cyc(DEAD + 5);
        chk("R8 gate_lo back after enable", gate_lo, 1'b1);
    endtask

    task automatic t_fault();
        idle();
        hin_raw = 1;
        cyc(LAT + 2);
        fault_stop = 1;
        cyc(1);
        chk("R7 gate_hi low at next edge", gate_hi, 1'b0);
        fault_stop = 0;
        cyc(DEAD - 1);
        chk("R8 gate_hi waits dead interval", gate_hi, 1'b0);
        cyc(1);
        chk("R8 gate_hi back after dead interval", gate_hi, 1'b1);
    endtask

    task automatic t_uv_high();
        idle();
        hin_raw = 1;
        cyc(LAT + 2);
        uv_high = 1;
        cyc(1);
        chk("R9 gate_hi low on uv_high", gate_hi, 1'b0);
        cyc(3);
        uv_high = 0;
        cyc(DEAD + 20);
        chk("R9 gate_hi stays low without new edge", gate_hi, 1'b0);
        hin_raw = 0;
        cyc(FILT + 5);
        hin_raw = 1;
        cyc(LAT - 1);
        chk("R9 gate_hi before latency of fresh edge", gate_hi, 1'b0);
        cyc(1);
        chk("R9 gate_hi on after fresh edge", gate_hi, 1'b1);
    endtask

    task automatic t_uv_low();
        idle();
        lin_raw = 1;
        cyc(LAT + 2);
        uv_low = 1;
        cyc(1);
        chk("R10 gate_lo low on uv_low", gate_lo, 1'b0);
        uv_low = 0;
        cyc(DEAD - 1);
        chk("R10 gate_lo waits dead interval", gate_lo, 1'b0);
        cyc(1);
        chk("R10 gate_lo follows level, no edge", gate_lo, 1'b1);
    endtask

    initial begin
        cyc(5);
        t_reset();
        cyc(5);
        t_inphase();
        t_short_pulse();
        t_handover(1'b1);
        t_handover(1'b0);
        t_interlock();
        t_enable();
        t_fault();
        t_uv_high();
        t_uv_low();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule